// File: doc/BRIEF.md
# Chip-Select Bus Cycle Sequencer

This block turns internal access requests into external bus cycles for memory-mapped chip-select areas. Each request carries:
- a byte address;
- a read/write flag;
- a word flag (16-bit access);
- a prefetch flag;
- write data.

The block decodes the address against a set of per-area base/mask pairs. An address that matches an area becomes one or more external beats. An address that matches no area becomes a single internal cycle with no external strobes.

Each external beat takes two clocks. In the first clock an address-latch pulse is driven with the new address. In the second clock the read strobe or the byte write strobes are active. After the last beat of an access, each area can ask for zero, one or two recovery clocks. During recovery the address is held and every strobe and chip select is idle, so slow devices get extra hold time.

Several cases produce more than one beat:
- A 16-bit access to an odd address on a 16-bit bus becomes two beats.
- A 16-bit access on an 8-bit bus becomes two beats.
- An instruction prefetch is always four read beats.

Between accesses the chip select of the last area stays asserted unless recovery or an internal cycle released it. This lets back-to-back accesses to one area keep it low throughout.

Top module: `csq_bus_seq`

## Requirements
- R1: The first clock after a request is accepted to an area drives `ale` high for exactly one clock with the beat address on `bus_addr`. The next clock is the strobe clock: `rd_n` is low for reads, or the selected write strobes are low for writes. Each beat is these two clocks.
- R2: Area g matches when `((addr ^ base_g) & mask_g) == 0`, and the lowest matching index wins. An address with no match produces one internal clock with `ale` low, all strobes high and every `cs_n` bit high. `bus_addr` is unchanged during that clock.
- R3: The recovery count of an area is 0 when its enable bit is 0, whatever its two-cycle bit says. With the enable bit set it is 1, or 2 when the two-cycle bit is also set. The recovery clocks follow the strobe clock of the last beat.
- R4: During every recovery clock `bus_addr` keeps the last beat's address, and `ale`, `rd_n`, `wrl_n`, `wrh_n` and all `cs_n` bits are inactive.
- R5: `wd_oe` is high in the strobe clock of a write. With a two-clock recovery it also stays high during the first recovery clock, with `bus_wdata` unchanged. Otherwise it drops after the strobe clock.
- R6: Every access to an area with recovery gets the same recovery again. Recovery completes before the next cycle starts, including when that cycle is internal.
- R7: The chip select of the active area is low from the address-latch clock through every beat of the access. It stays low across idle clocks when the access had no recovery. A second access to the same area therefore sees no high pulse on it. At most one `cs_n` bit is ever low.
- R8: On a 16-bit bus (`bus_is16`=1), a word access at an odd address A makes two beats. The first beat is at A on the high lane (`wrh_n`) and carries data bits [7:0]. The second beat is at A+1 on the low lane (`wrl_n`) and carries bits [15:8]. Each byte is driven on both halves of `bus_wdata`. An aligned word is one beat with both strobes and `bus_wdata` equal to the request data.
- R9: A prefetch is four read beats at A, A+2, A+4, A+6 on a 16-bit bus, or A..A+3 on an 8-bit bus. Recovery is added only after the fourth beat.
- R10: On an 8-bit bus every write uses only `wrl_n`, and a word access is two beats at A and A+1. A byte access on a 16-bit bus uses `wrh_n` at an odd address and `wrl_n` at an even address.
- R11: `req_ready` is high only when no access or recovery is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high. In idle clocks all strobes are high, `ale` is low and `wd_oe` is low.
- R12: Under reset `req_ready` is 1, `ale` is 0, `bus_addr` is 0, all `cs_n` bits and strobes are 1, and `wd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_prefetch | input | 1 | Four-beat instruction fetch (read) |
| req_wdata | input | 16 | Write data |
| bus_is16 | input | 1 | External bus width: 1 = 16 bits, 0 = 8 bits |
| area_base | input | N_AREA*ADDR_W | Per-area match base, area g at bits g*ADDR_W |
| area_mask | input | N_AREA*ADDR_W | Per-area match mask |
| area_rec_en | input | N_AREA | Per-area recovery enable |
| area_rec_two | input | N_AREA | Per-area two-clock recovery select |
| ale | output | 1 | Address latch pulse |
| bus_addr | output | ADDR_W | External address |
| cs_n | output | N_AREA | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wrl_n | output | 1 | Active-low low-byte write strobe |
| wrh_n | output | 1 | Active-low high-byte write strobe |
| wd_oe | output | 1 | Write data drive enable |
| bus_wdata | output | 16 | Write data lanes |

## Verification
The bench uses the default four areas and a 24-bit address. The areas are set up so that all three recovery counts occur. One area has only its two-cycle bit set. Two areas overlap, so the lowest-index priority decides.

The bench switches `bus_is16` between phases. This brings in reach the odd-address split, the 8-bit word split and both prefetch strides. It also covers recovery before an internal cycle and chip-select parking across idle clocks.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALE  = 3'd1,
    PH_STB  = 3'd2,
    PH_REC  = 3'd3,
    PH_INT  = 3'd4
  } phase_t;

  // recovery clocks chosen by an area's two configuration bits
  function automatic logic [1:0] rec_cycles(input logic en, input logic two);
    if (!en) return 2'd0;
    return two ? 2'd2 : 2'd1;
  endfunction

  // number of external beats an access needs
  function automatic logic [2:0] beat_total(input logic pf, input logic word,
                                            input logic b16, input logic a0);
    if (pf) return 3'd4;
    if (word && (!b16 || a0)) return 3'd2;
    return 3'd1;
  endfunction

  // address increment between beats
  function automatic logic [1:0] addr_step(input logic pf, input logic b16);
    return (pf && b16) ? 2'd2 : 2'd1;
  endfunction

  // active byte lanes, {high, low}
  function automatic logic [1:0] lane_sel(input logic b16, input logic full, input logic a0);
    if (!b16) return 2'b01;
    if (full) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  // data presented for a beat; a lone byte is copied to both lanes
  function automatic logic [DATA_W-1:0] beat_data(input logic [DATA_W-1:0] wd,
                                                  input logic full, input logic second);
    logic [LANE_W-1:0] b;
    b = second ? wd[DATA_W-1:LANE_W] : wd[LANE_W-1:0];
    if (full) return wd;
    return {b, b};
  endfunction
endpackage

// File: rtl/csq_area_decode.sv
module csq_area_decode #(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_AREA*ADDR_W-1:0] base,
  input  logic [N_AREA*ADDR_W-1:0] mask,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx
);
  logic [N_AREA-1:0] match;

  for (genvar g = 0; g < N_AREA; g++) begin : g_cmp
    assign match[g] = ((addr ^ base[g*ADDR_W +: ADDR_W]) & mask[g*ADDR_W +: ADDR_W]) == '0;
  end

  // lowest index has priority: scan downwards so it is written last
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/csq_cycle_ctl.sv
module csq_cycle_ctl
  import csq_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_prefetch,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_is16,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [1:0]        rec_sel,
  output logic              req_ready,
  output phase_t            ph,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  area_q,
  output logic              cs_q,
  output logic              wr_q,
  output logic              full_q,
  output logic              b16_q,
  output logic              beat_odd,
  output logic [DATA_W-1:0] wdata_q,
  output logic [1:0]        rec_tot,
  output logic [1:0]        rec_left,
  output logic              more_beats
);
  logic [2:0] beats_left;
  logic [1:0] step_q;
  logic       accept_w;
  logic       last_beat_w;

  assign req_ready   = (ph == PH_IDLE);
  assign accept_w    = req_ready && req_valid;
  assign more_beats  = (ph == PH_STB) && (beats_left != 3'd0);
  assign last_beat_w = (ph == PH_STB) && (beats_left == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      addr_q     <= '0;
      area_q     <= '0;
      cs_q       <= 1'b0;
      wr_q       <= 1'b0;
      full_q     <= 1'b0;
      b16_q      <= 1'b0;
      beat_odd   <= 1'b0;
      beats_left <= '0;
      step_q     <= '0;
      wdata_q    <= '0;
      rec_tot    <= '0;
      rec_left   <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (accept_w) begin
            if (hit) begin
              ph         <= PH_ALE;
              addr_q     <= req_addr;
              area_q     <= hit_idx;
              cs_q       <= 1'b1;
              wr_q       <= req_write && !req_prefetch;
              full_q     <= req_word && bus_is16 && !req_addr[0] && !req_prefetch;
              b16_q      <= bus_is16;
              beat_odd   <= 1'b0;
              beats_left <= beat_total(req_prefetch, req_word, bus_is16, req_addr[0]) - 3'd1;
              step_q     <= addr_step(req_prefetch, bus_is16);
              wdata_q    <= req_wdata;
              rec_tot    <= rec_sel;
            end else begin
              ph   <= PH_INT;
              cs_q <= 1'b0;
            end
          end
        end
        PH_ALE: ph <= PH_STB;
        PH_STB: begin
          if (more_beats) begin
            ph         <= PH_ALE;
            beats_left <= beats_left - 3'd1;
            addr_q     <= addr_q + ADDR_W'(step_q);
            beat_odd   <= ~beat_odd;
          end else if (last_beat_w && rec_tot != 2'd0) begin
            ph       <= PH_REC;
            rec_left <= rec_tot;
            cs_q     <= 1'b0;
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_REC: begin
          rec_left <= rec_left - 2'd1;
          if (rec_left <= 2'd1) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csq_pin_drive.sv
module csq_pin_drive
  import csq_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  phase_t            ph,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [IDX_W-1:0]  area_q,
  input  logic              cs_q,
  input  logic              wr_q,
  input  logic              full_q,
  input  logic              b16_q,
  input  logic              beat_odd,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [1:0]        rec_tot,
  input  logic [1:0]        rec_left,
  output logic              ale,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [N_AREA-1:0] cs_n,
  output logic              rd_n,
  output logic              wrl_n,
  output logic              wrh_n,
  output logic              wd_oe,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              in_rec,
  output logic              rec_first
);
  logic       stb;
  logic [1:0] lanes;

  assign stb       = (ph == PH_STB);
  assign in_rec    = (ph == PH_REC);
  assign rec_first = in_rec && (rec_left == rec_tot);
  assign lanes     = lane_sel(b16_q, full_q, addr_q[0]);

  assign ale       = (ph == PH_ALE);
  assign bus_addr  = addr_q;
  assign rd_n      = !(stb && !wr_q);
  assign wrl_n     = !(stb && wr_q && lanes[0]);
  assign wrh_n     = !(stb && wr_q && lanes[1]);
  assign wd_oe     = wr_q && (stb || (rec_first && rec_tot == 2'd2));
  assign bus_wdata = beat_data(wdata_q, full_q, beat_odd);

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign cs_n[g] = !(cs_q && (area_q == IDX_W'(g)));
  end
endmodule

// File: rtl/csq_bus_seq.sv
module csq_bus_seq
  import csq_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24,
  localparam int IDX_W = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic                     req_prefetch,
  input  logic [15:0]              req_wdata,
  input  logic                     bus_is16,
  input  logic [N_AREA*ADDR_W-1:0] area_base,
  input  logic [N_AREA*ADDR_W-1:0] area_mask,
  input  logic [N_AREA-1:0]        area_rec_en,
  input  logic [N_AREA-1:0]        area_rec_two,
  output logic                     ale,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [N_AREA-1:0]        cs_n,
  output logic                     rd_n,
  output logic                     wrl_n,
  output logic                     wrh_n,
  output logic                     wd_oe,
  output logic [15:0]              bus_wdata
);
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [1:0]        rec_sel;
  phase_t            ph;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  area_q;
  logic              cs_q, wr_q, full_q, b16_q, beat_odd;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        rec_tot, rec_left;
  logic              more_beats, in_rec, rec_first;

  csq_area_decode #(.N_AREA(N_AREA), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .base(area_base), .mask(area_mask), .hit(hit), .idx(hit_idx)
  );

  assign rec_sel = rec_cycles(area_rec_en[hit_idx], area_rec_two[hit_idx]);

  csq_cycle_ctl #(.N_AREA(N_AREA), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_prefetch(req_prefetch),
    .req_wdata(req_wdata), .bus_is16(bus_is16), .hit(hit), .hit_idx(hit_idx),
    .rec_sel(rec_sel), .req_ready(req_ready), .ph(ph), .addr_q(addr_q),
    .area_q(area_q), .cs_q(cs_q), .wr_q(wr_q), .full_q(full_q), .b16_q(b16_q),
    .beat_odd(beat_odd), .wdata_q(wdata_q), .rec_tot(rec_tot),
    .rec_left(rec_left), .more_beats(more_beats)
  );

  csq_pin_drive #(.N_AREA(N_AREA), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pins (
    .ph(ph), .addr_q(addr_q), .area_q(area_q), .cs_q(cs_q), .wr_q(wr_q),
    .full_q(full_q), .b16_q(b16_q), .beat_odd(beat_odd), .wdata_q(wdata_q),
    .rec_tot(rec_tot), .rec_left(rec_left), .ale(ale), .bus_addr(bus_addr),
    .cs_n(cs_n), .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .wd_oe(wd_oe),
    .bus_wdata(bus_wdata), .in_rec(in_rec), .rec_first(rec_first)
  );
endmodule

// File: rtl/csq_bus_seq_chk.sv
module csq_bus_seq_chk #(
  parameter int N_AREA = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ale,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_AREA-1:0] cs_n,
  input logic              rd_n,
  input logic              wrl_n,
  input logic              wrh_n,
  input logic              wd_oe,
  input logic [15:0]       bus_wdata,
  input logic              in_rec,
  input logic              rec_first,
  input logic              more_beats
);
  a_r1_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r1_strobe_follows_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !(wrl_n && wrh_n)));

  a_r4_rec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_rec |-> (rd_n && wrl_n && wrh_n && !ale && (&cs_n)));

  a_r4_rec_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_rec |-> $stable(bus_addr));

  a_r5_rec_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rec && wd_oe) |-> ($stable(bus_wdata) && $past(wd_oe)));

  a_r5_oe_first_rec_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rec && !rec_first) |-> !wd_oe);

  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r7_cs_across_beats: assert property (@(posedge clk) disable iff (!rst_n)
    more_beats |=> ($stable(cs_n) && ale));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && rd_n && wrl_n && wrh_n && !wd_oe));
endmodule

bind csq_bus_seq csq_bus_seq_chk #(.N_AREA(N_AREA), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ale(ale), .bus_addr(bus_addr),
  .cs_n(cs_n), .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .wd_oe(wd_oe),
  .bus_wdata(bus_wdata), .in_rec(in_rec), .rec_first(rec_first),
  .more_beats(more_beats)
);

// File: tb/tb_csq_bus_seq.sv
`timescale 1ns/1ps
module tb_csq_bus_seq;
  localparam int AW = 24;
  localparam int NA = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_word, req_prefetch, bus_is16;
  logic [AW-1:0] req_addr;
  logic [15:0] req_wdata;
  logic [NA*AW-1:0] area_base, area_mask;
  logic [NA-1:0] area_rec_en, area_rec_two;
  logic ale, rd_n, wrl_n, wrh_n, wd_oe;
  logic [AW-1:0] bus_addr;
  logic [NA-1:0] cs_n;
  logic [15:0] bus_wdata;

  logic [AW-1:0] cfg_base [NA];
  logic [AW-1:0] cfg_mask [NA];

  csq_bus_seq #(.N_AREA(NA), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_prefetch(req_prefetch), .req_wdata(req_wdata), .bus_is16(bus_is16),
    .area_base(area_base), .area_mask(area_mask), .area_rec_en(area_rec_en),
    .area_rec_two(area_rec_two), .ale(ale), .bus_addr(bus_addr), .cs_n(cs_n),
    .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .wd_oe(wd_oe), .bus_wdata(bus_wdata)
  );

  logic [49:0] exq [$];
  string       tagq [$];
  int nvec = 0, nfail = 0, cyc = 0;
  bit run = 0;
  logic [AW-1:0] m_addr;
  logic [NA-1:0] m_cs;

  // {ale, addr, cs_n, rd_n, wrl_n, wrh_n, oe, wdata, ready}
  function automatic logic [49:0] mk(input logic a, input logic [AW-1:0] ad,
      input logic [NA-1:0] cs, input logic rd, input logic wl, input logic wh,
      input logic oe, input logic [15:0] wd, input logic rdy);
    return {a, ad, cs, rd, wl, wh, oe, wd, rdy};
  endfunction

  function automatic int area_of(input logic [AW-1:0] a);
    int r = -1;
    for (int i = NA - 1; i >= 0; i--)
      if (((a ^ cfg_base[i]) & cfg_mask[i]) == '0) r = i;
    return r;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // per-clock comparison against the model's expected pin vector
  always @(negedge clk) begin : cmp
    logic [49:0] e, g;
    string t;
    if (run) begin
      if (exq.size() > 0) begin
        e = exq.pop_front();
        t = tagq.pop_front();
      end else begin
        e = mk(1'b0, m_addr, m_cs, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1);
        t = "R11";
      end
      g = mk(ale, bus_addr, cs_n, rd_n, wrl_n, wrh_n, wd_oe,
             e[17] ? bus_wdata : 16'h0, req_ready);
      nvec++;
      if (g !== e) begin
        nfail++;
        $display("FAIL %s at %0t: got %h expected %h", t, $time, g, e);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic issue(input logic [AW-1:0] a, input logic w, input logic word,
                       input logic pf, input logic [15:0] wd, input string t);
    int idx, nb, step, nrec;
    logic full, wr;
    logic [AW-1:0] ak;
    logic [15:0] dk;
    logic [1:0] ln;
    logic [NA-1:0] csv;
    do begin @(posedge clk); #1; end while (exq.size() != 0);
    req_valid = 1'b1; req_addr = a; req_write = w; req_word = word;
    req_prefetch = pf; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    idx = area_of(a);
    if (idx < 0) begin
      exq.push_back(mk(1'b0, m_addr, '1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0));
      tagq.push_back(t);
      m_cs = '1;
      return;
    end
    wr   = w && !pf;
    nb   = pf ? 4 : ((word && (!bus_is16 || a[0])) ? 2 : 1);
    step = (pf && bus_is16) ? 2 : 1;
    full = word && bus_is16 && !pf && nb == 1;
    nrec = area_rec_en[idx] ? (area_rec_two[idx] ? 2 : 1) : 0;
    csv  = ~(NA'(1) << idx);
    ak = a; dk = '0;
    for (int k = 0; k < nb; k++) begin
      ak = a + AW'(k * step);
      dk = full ? wd : ((k == 0) ? {wd[7:0], wd[7:0]} : {wd[15:8], wd[15:8]});
      ln = !wr ? 2'b00 : (!bus_is16 ? 2'b01 : (full ? 2'b11 : (ak[0] ? 2'b10 : 2'b01)));
      exq.push_back(mk(1'b1, ak, csv, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0));
      tagq.push_back(t);
      exq.push_back(mk(1'b0, ak, csv, wr, !ln[0], !ln[1], wr, wr ? dk : 16'h0, 1'b0));
      tagq.push_back(t);
    end
    for (int r = 0; r < nrec; r++) begin
      exq.push_back(mk(1'b0, ak, '1, 1'b1, 1'b1, 1'b1, wr && nrec == 2 && r == 0,
                       (wr && nrec == 2 && r == 0) ? dk : 16'h0, 1'b0));
      tagq.push_back(t);
    end
    m_addr = ak;
    m_cs   = (nrec == 0) ? csv : '1;
  endtask

  initial begin
    // area0: 0x1xxxxx no recovery; area1: 0x2xxxxx one clock;
    // area2: 0x5xxxxx two clocks (wins over area3); area3: 0x4-0x7xxxxx, two bit only
    cfg_base[0] = 24'h100000; cfg_mask[0] = 24'hF00000;
    cfg_base[1] = 24'h200000; cfg_mask[1] = 24'hF00000;
    cfg_base[2] = 24'h500000; cfg_mask[2] = 24'hF00000;
    cfg_base[3] = 24'h400000; cfg_mask[3] = 24'hC00000;
    area_base = {cfg_base[3], cfg_base[2], cfg_base[1], cfg_base[0]};
    area_mask = {cfg_mask[3], cfg_mask[2], cfg_mask[1], cfg_mask[0]};
    area_rec_en  = 4'b0110;
    area_rec_two = 4'b1100;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_word = 1'b0; req_prefetch = 1'b0; req_wdata = '0; bus_is16 = 1'b1;
    repeat (3) @(negedge clk);
    nvec++; // R12 reset state
    if ({req_ready, ale, bus_addr, cs_n, rd_n, wrl_n, wrh_n, wd_oe} !==
        {1'b1, 1'b0, 24'h0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0}) begin
      nfail++;
      $display("FAIL R12: got %b %b %h %b %b%b%b %b expected 1 0 000000 1111 111 0",
               req_ready, ale, bus_addr, cs_n, rd_n, wrl_n, wrh_n, wd_oe);
    end
    @(posedge clk); #1;
    rst_n = 1'b1; m_addr = '0; m_cs = '1; run = 1'b1;

    issue(24'h100010, 1'b0, 1'b0, 1'b0, 16'h0000, "R1");   // byte read, area0
    issue(24'h100020, 1'b1, 1'b1, 1'b0, 16'hBEEF, "R7");   // same area, cs parked low
    issue(24'h100031, 1'b1, 1'b1, 1'b0, 16'hA55A, "R8");   // odd word split
    issue(24'h100034, 1'b1, 1'b0, 1'b0, 16'h0077, "R10");  // even byte, low lane
    issue(24'h100035, 1'b1, 1'b0, 1'b0, 16'h0066, "R10");  // odd byte, high lane
    issue(24'h200004, 1'b0, 1'b0, 1'b0, 16'h0000, "R3");   // one recovery clock
    issue(24'h200005, 1'b1, 1'b0, 1'b0, 16'h00C3, "R6");   // recovery repeated
    issue(24'h050000, 1'b0, 1'b0, 1'b0, 16'h0000, "R2");   // internal after recovery
    issue(24'h500002, 1'b1, 1'b1, 1'b0, 16'h1234, "R5");   // two clocks, data held
    issue(24'h500100, 1'b0, 1'b1, 1'b0, 16'h0000, "R4");   // two clocks, read
    issue(24'h500101, 1'b1, 1'b0, 1'b0, 16'h0099, "R6");
    issue(24'h0F0000, 1'b1, 1'b1, 1'b0, 16'h4321, "R6");   // internal write after recovery
    issue(24'h100100, 1'b0, 1'b0, 1'b1, 16'h0000, "R9");   // prefetch, stride 2
    issue(24'h500200, 1'b1, 1'b1, 1'b1, 16'hFFFF, "R9");   // prefetch, write ignored, rec after last
    issue(24'h400010, 1'b1, 1'b1, 1'b0, 16'h5AA5, "R3");   // two bit alone: no recovery
    issue(24'h400012, 1'b0, 1'b0, 1'b0, 16'h0000, "R7");
    issue(24'hF00000, 1'b0, 1'b0, 1'b0, 16'h0000, "R2");   // no area
    issue(24'h5FFFFE, 1'b0, 1'b0, 1'b0, 16'h0000, "R2");   // overlap, area2 wins
    @(posedge clk); #1; bus_is16 = 1'b0;
    issue(24'h200010, 1'b1, 1'b1, 1'b0, 16'hCAFE, "R10");  // 8-bit word split
    issue(24'h100003, 1'b1, 1'b0, 1'b0, 16'h0011, "R10");  // odd byte, low lane
    issue(24'h100200, 1'b0, 1'b0, 1'b1, 16'h0000, "R9");   // prefetch, stride 1
    issue(24'h500300, 1'b1, 1'b1, 1'b0, 16'h8421, "R5");
    @(posedge clk); #1; bus_is16 = 1'b1;
    issue(24'h100041, 1'b0, 1'b1, 1'b0, 16'h0000, "R8");   // odd word read split
    while (exq.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
    summary();
  end
endmodule